// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is the data register of a boundary scan path. It is a parameterised string of scan cells, one for each pin position. Each cell holds a capture/shift flop and a parallel update latch. A TAP controller outside the block selects the chain and pulses single-cycle strobes. A capture strobe takes a snapshot of the pin values into the flops. A shift strobe moves the flops one place toward the serial output and takes a new bit in at the far end. An update strobe copies the flops into the update latches, which then hold steady through later captures and shifts.

The mode select decides what reaches the pins. In functional mode the core's own output data and enable go through unchanged. In external-test mode the update latches drive the pin values. One control cell at a parameterised index then enables the output bus when it holds 1 and tri-states it when it holds 0. In the high-impedance sample mode the output bus is disabled whatever the latches or the core ask for. Captured data leaves at the serial output while new preload data enters at the serial input, in one pass.

Top module: `bscan_chain`

## Requirements
- R1: While `rst` is high, every capture flop and every update latch clears to 0. After reset and before any update, external-test mode gives `pin_drv` = 0 and `bus_oe` = 0, and `tdo` is 0.
- R2: A clock edge with `chain_sel` and `cap_en` high loads `pin_in` into the chain. Right after that edge, `tdo` shows `pin_in[0]`.
- R3: A clock edge with `chain_sel` and `shift_en` high, and `cap_en` low, moves every cell one place toward bit 0 and loads `tdi` into bit N-1. `tdo` is always bit 0, so after k shifts following a capture it shows captured bit k. After N shifts, the first `tdi` bit sits in bit 0.
- R4: One pass of N shifts sends out all N captured bits while it loads N new preload bits. Afterward the chain holds exactly the bits that came in at `tdi`.
- R5: A clock edge with `chain_sel` and `upd_en` high copies the chain into the update latches. The latches keep their value through any later capture or shift that has no update.
- R6: When `mode_sel` = 2'b01 (external test), `pin_drv` equals the update latches.
- R7: In external test, `bus_oe` equals the update latch at index TRI_IDX (default 85), active high: 1 drives the bus and 0 tri-states it.
- R8: When `mode_sel` = 2'b10 (high-impedance sample), `bus_oe` is 0 regardless of `func_oe` and the latches.
- R9: When `mode_sel` = 2'b00 or 2'b11, `pin_drv` = `func_d` and `bus_oe` = `func_oe`, whatever the latches hold.
- R10: If `cap_en` and `shift_en` are both high on the same edge, the capture takes place and the shift does not.
- R11: While `chain_sel` is low, `cap_en`, `shift_en` and `upd_en` have no effect on the chain or on the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test-logic reset |
| chain_sel | input | 1 | This chain is the selected data register |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| mode_sel | input | 2 | 00 functional, 01 external test, 10 high-impedance sample, 11 functional |
| tdi | input | 1 | Serial data in, enters at bit N-1 |
| pin_in | input | N | Pin values to capture |
| func_d | input | N | Core output data for functional mode |
| func_oe | input | 1 | Core output-bus enable for functional mode |
| tdo | output | 1 | Serial data out, bit 0 of the chain |
| pin_drv | output | N | Values driven toward the pins |
| bus_oe | output | 1 | Output-bus enable, 1 drives |

## Verification
The bench builds the block with its defaults, a 90-cell chain with the control cell at index 85, so every shift pass crosses the full length. Because the control cell sits deep in the chain, a wrong shift direction or an off-by-one in the shift count puts the wrong bit into the control latch. That error then shows up in `bus_oe` as well as in the scoreboard's serial stream. Preload patterns with the control bit set and with it cleared bring both states of the output enable within reach. The same patterns also serve the strobe-priority case and the deselected case.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        BS_FUNC   = 2'b00,
        BS_EXTEST = 2'b01,
        BS_HIGHZ  = 2'b10,
        BS_SPARE  = 2'b11
    } bs_mode_e;

    typedef struct packed {
        logic cap;
        logic sh;
        logic upd;
    } bs_strobe_t;

    // Strobes only act when the chain is selected; capture wins over shift.
    function automatic bs_strobe_t bs_qualify(input logic sel, input logic cap,
                                              input logic sh, input logic upd);
        bs_strobe_t r;
        r.cap = sel & cap;
        r.sh  = sel & sh & ~cap;
        r.upd = sel & upd;
        return r;
    endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bs_strobe_t stb,
    input  logic       par_in,
    input  logic       ser_in,
    output logic       cap_q,
    output logic       upd_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= 1'b0;
        else if (stb.cap)
            cap_q <= par_in;
        else if (stb.sh)
            cap_q <= ser_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            upd_q <= 1'b0;
        else if (stb.upd)
            upd_q <= cap_q;
    end

endmodule

// File: rtl/bscan_outmux.sv
module bscan_outmux
    import bscan_pkg::*;
#(
    parameter int N       = 90,
    parameter int TRI_IDX = 85
) (
    input  bs_mode_e       mode,
    input  logic [N-1:0]   latch_q,
    input  logic [N-1:0]   func_d,
    input  logic           func_oe,
    output logic [N-1:0]   pin_drv,
    output logic           bus_oe
);

    always_comb begin
        unique case (mode)
            BS_EXTEST: begin
                pin_drv = latch_q;
                bus_oe  = latch_q[TRI_IDX];
            end
            BS_HIGHZ: begin
                pin_drv = func_d;
                bus_oe  = 1'b0;
            end
            default: begin
                pin_drv = func_d;
                bus_oe  = func_oe;
            end
        endcase
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N       = 90,
    parameter int TRI_IDX = 85
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         chain_sel,
    input  logic         cap_en,
    input  logic         shift_en,
    input  logic         upd_en,
    input  logic [1:0]   mode_sel,
    input  logic         tdi,
    input  logic [N-1:0] pin_in,
    input  logic [N-1:0] func_d,
    input  logic         func_oe,
    output logic         tdo,
    output logic [N-1:0] pin_drv,
    output logic         bus_oe
);

    localparam int LAST = N - 1;

    bs_strobe_t   stb;
    bs_mode_e     mode;
    logic [N-1:0] chain_q;
    logic [N-1:0] latch_q;
    logic [N-1:0] ser_link;

    assign stb  = bs_qualify(chain_sel, cap_en, shift_en, upd_en);
    assign mode = bs_mode_e'(mode_sel);

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            if (i == LAST) begin : g_head
                assign ser_link[i] = tdi;
            end else begin : g_body
                assign ser_link[i] = chain_q[i+1];
            end
            bscan_cell u_cell (
                .clk    (clk),
                .rst    (rst),
                .stb    (stb),
                .par_in (pin_in[i]),
                .ser_in (ser_link[i]),
                .cap_q  (chain_q[i]),
                .upd_q  (latch_q[i])
            );
        end
    endgenerate

    assign tdo = chain_q[0];

    bscan_outmux #(.N(N), .TRI_IDX(TRI_IDX)) u_mux (
        .mode    (mode),
        .latch_q (latch_q),
        .func_d  (func_d),
        .func_oe (func_oe),
        .pin_drv (pin_drv),
        .bus_oe  (bus_oe)
    );

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int N       = 90,
    parameter int TRI_IDX = 85
) (
    input logic         clk,
    input logic         rst,
    input logic         chain_sel,
    input logic         cap_en,
    input logic         shift_en,
    input logic         upd_en,
    input logic [1:0]   mode_sel,
    input logic         tdi,
    input logic [N-1:0] pin_in,
    input logic [N-1:0] func_d,
    input logic         func_oe,
    input logic         tdo,
    input logic [N-1:0] pin_drv,
    input logic         bus_oe,
    input logic [N-1:0] chain_q,
    input logic [N-1:0] latch_q
);

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (chain_sel && cap_en) |=> (chain_q == $past(pin_in)));

    p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (chain_sel && shift_en && !cap_en) |=>
            (chain_q == {$past(tdi), $past(chain_q[N-1:1])}));

    p_tdo_bit0_r3: assert property (@(posedge clk) disable iff (rst)
        tdo == chain_q[0]);

    p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(chain_sel && upd_en) |=> $stable(latch_q));

    p_ext_drive_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01) |-> (pin_drv == latch_q));

    p_ext_oe_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01) |-> (bus_oe == pin_drv[TRI_IDX]));

    p_highz_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b10) |-> !bus_oe);

    p_func_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_sel[0] == mode_sel[1]) |-> (pin_drv == func_d && bus_oe == func_oe));

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !chain_sel |=> ($stable(chain_q) && $stable(latch_q)));

endmodule

bind bscan_chain bscan_chain_chk #(.N(N), .TRI_IDX(TRI_IDX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .chain_sel (chain_sel),
    .cap_en    (cap_en),
    .shift_en  (shift_en),
    .upd_en    (upd_en),
    .mode_sel  (mode_sel),
    .tdi       (tdi),
    .pin_in    (pin_in),
    .func_d    (func_d),
    .func_oe   (func_oe),
    .tdo       (tdo),
    .pin_drv   (pin_drv),
    .bus_oe    (bus_oe),
    .chain_q   (chain_q),
    .latch_q   (latch_q)
);

// File: tb/bscan_chain_test.sv
`timescale 1ns/1ps
module bscan_chain_test;

    localparam int N   = 90;
    localparam int TRI = 85;

    logic         clk = 1'b0;
    logic         rst;
    logic         chain_sel, cap_en, shift_en, upd_en, tdi, func_oe;
    logic [1:0]   mode_sel;
    logic [N-1:0] pin_in, func_d;
    logic         tdo, bus_oe;
    logic [N-1:0] pin_drv;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic  bit_exp;
        string tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    logic [N-1:0] pat_a, pat_b, pat_c, pat_p, pat_q, pat_f;

    always #2.5 clk = ~clk;

    bscan_chain #(.N(N), .TRI_IDX(TRI)) uut (
        .clk(clk), .rst(rst), .chain_sel(chain_sel), .cap_en(cap_en),
        .shift_en(shift_en), .upd_en(upd_en), .mode_sel(mode_sel), .tdi(tdi),
        .pin_in(pin_in), .func_d(func_d), .func_oe(func_oe),
        .tdo(tdo), .pin_drv(pin_drv), .bus_oe(bus_oe)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: one expected serial bit per shift edge, compared at the following falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (tdo !== it.bit_exp) begin
                n_err++;
                $display("FAIL %s actual=%b expected=%b", it.tag, tdo, it.bit_exp);
            end
        end
    end

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_capture(input logic [N-1:0] pins);
        step();
        pin_in = pins;
        cap_en = 1'b1;
        step();
        cap_en = 1'b0;
    endtask

    task automatic pulse_update;
        step();
        upd_en = 1'b1;
        step();
        upd_en = 1'b0;
    endtask

    // Driver: shifts `count` bits of pre in (LSB first) and pushes the tdo expected after each edge.
    task automatic shift_pass(input logic [N-1:0] cap_img, input logic [N-1:0] pre,
                              input int count, input string tag);
        for (int j = 0; j < count; j++) begin
            sb_item_t it;
            step();
            shift_en = 1'b1;
            tdi      = pre[j];
            it.bit_exp = (j + 1 < N) ? cap_img[j+1] : pre[j+1-N];
            it.tag     = tag;
            sb_q.push_back(it);
        end
        step();
        shift_en = 1'b0;
        step();
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            pat_a[i] = (i % 3 == 0);
            pat_b[i] = (i % 2 == 1);
            pat_c[i] = (i % 4 == 0);
            pat_p[i] = ((i * 7) % 5 < 2);
            pat_q[i] = ~pat_p[i];
            pat_f[i] = (i % 5 == 2);
        end
        rst = 1'b1; chain_sel = 1'b0; cap_en = 1'b0; shift_en = 1'b0; upd_en = 1'b0;
        tdi = 1'b0; mode_sel = 2'b01; pin_in = '1; func_d = pat_f; func_oe = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1: reset state
        check("R1 pin_drv", pin_drv, '0);
        check("R1 bus_oe", N'(bus_oe), '0);
        check("R1 tdo", N'(tdo), '0);

        // R2, R3, R4: capture pattern A, shift it out while preloading P
        chain_sel = 1'b1;
        pulse_capture(pat_a);
        check("R2 tdo after capture", N'(tdo), N'(pat_a[0]));
        shift_pass(pat_a, pat_p, N, "R3 R4 serial order A/P");

        // R5, R6, R7: update with control bit set
        pulse_update();
        check("R6 pin_drv extest", pin_drv, pat_p);
        check("R7 bus_oe control=1", N'(bus_oe), N'(1'b1));

        // R8: high-impedance sample mode
        mode_sel = 2'b10; step();
        check("R8 bus_oe highz", N'(bus_oe), '0);

        // R9: functional modes
        mode_sel = 2'b00; step();
        check("R9 pin_drv mode00", pin_drv, pat_f);
        check("R9 bus_oe mode00", N'(bus_oe), N'(1'b1));
        mode_sel = 2'b11; func_oe = 1'b0; step();
        check("R9 pin_drv mode11", pin_drv, pat_f);
        check("R9 bus_oe mode11", N'(bus_oe), '0);

        // R5: latches hold through capture and partial shift
        mode_sel = 2'b01;
        pulse_capture(pat_b);
        shift_pass(pat_b, pat_q, 10, "R3 partial B");
        check("R5 latches held", pin_drv, pat_p);

        // R7: preload with control bit clear
        pulse_capture(pat_b);
        shift_pass(pat_b, pat_q, N, "R4 serial order B/Q");
        pulse_update();
        check("R6 pin_drv Q", pin_drv, pat_q);
        check("R7 bus_oe control=0", N'(bus_oe), '0);

        // R10: capture wins over shift
        step();
        pin_in = pat_c; cap_en = 1'b1; shift_en = 1'b1; tdi = 1'b1;
        step();
        cap_en = 1'b0; shift_en = 1'b0;
        check("R10 tdo capture priority", N'(tdo), N'(pat_c[0]));
        shift_pass(pat_c, pat_p, N, "R10 chain holds C");

        // R11: strobes ignored while deselected (chain holds P, latches hold Q)
        chain_sel = 1'b0;
        pulse_capture(~pat_c);
        step(); shift_en = 1'b1; tdi = 1'b0; step(); shift_en = 1'b0;
        pulse_update();
        check("R11 tdo unchanged", N'(tdo), N'(pat_p[0]));
        check("R11 latches unchanged", pin_drv, pat_q);
        chain_sel = 1'b1;
        shift_pass(pat_p, pat_q, N, "R11 chain still P");

        repeat (2) step();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule